// File: doc/BRIEF.md
# Receive FIFO Readout Formatter

This block drains a byte-wide packet FIFO toward a host port that reads one 32-bit DWORD at a time. Each packet's length arrives as an entry in a small length FIFO, and the packet's bytes arrive in a byte FIFO. When the host reads, the formatter builds each DWORD from the right bytes. It places a programmable number of zero bytes (0 to 31) ahead of the first packet byte. It zeroes the lanes past the packet's end. It then adds zero filler DWORDs until the packet's DWORD total is a multiple of the selected end boundary. Byte lanes are little-endian: stream byte position p lands in lane p mod 4 of DWORD p/4.

A 12-bit DWORD countdown decrements on every accepted host read. It raises an interrupt when it steps from one to zero. A one-cycle dump command empties both FIFOs at once, and the dump flag reads back as zero once that cycle is over. Packet lengths must be at least 1 byte.

Top module: `rxf_readout`

## Requirements
- R1: `cfg_align` selects the DWORD multiple a packet's readout is padded to: 00 gives 1 (4-byte), 01 gives 4 (16-byte), 10 gives 8 (32-byte), and 11 behaves like 00. A packet takes exactly ceil((offset+len)/4) DWORDs rounded up to that multiple. After the last one, `rd_avail` is low until another packet is present.
- R2: Offset bytes, lanes past the last packet byte, and filler DWORDs all read as zero.
- R3: The offset and alignment are captured at the first DWORD read of a packet. A `cfg_wr` made after that read does not change the rest of that packet, and it applies from the next packet.
- R4: With offset N (0..31), packet byte i appears at stream position N+i, in lane (N+i) mod 4 of DWORD (N+i)/4.
- R5: Each accepted read lowers the count by one, and the count stops at zero. A read that takes the count from 1 to 0 sets `irq`.
- R6: A `cnt_wr` loads `cnt_wdata`, and the countdown carries on from that value. A same-cycle read does not decrement. A nonzero load clears `irq`.
- R7: `irq_clr` clears `irq` unless the same cycle sets it.
- R8: `cfg_wr` with `cfg_dump`=1 empties both FIFOs and drops the packet in progress, including any filler still owed. `cfg_rdata[12]` reads 1 for exactly the next cycle and then 0.
- R9: When the current DWORD cannot be formed, `rd_avail` is 0 and `rd_data` is 0. A `rd_en` in that state moves no pointer and does not change the count.
- R10: After reset, `rd_avail`=0, `rd_data`=0, `irq`=0, `cfg_rdata`=0 and `in_ready`=1.
- R11: `in_ready` is 0 while the byte FIFO holds DEPTH bytes, and bytes offered in that state are dropped.
- R12: `cfg_rdata` layout: [1:0] alignment, [8:4] offset, [12] dump flag, [27:16] count; all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Packet byte offered |
| in_byte | input | 8 | Packet byte |
| in_ready | output | 1 | Byte FIFO has room |
| st_valid | input | 1 | Push a packet length entry |
| st_len | input | LEN_W | Packet length in bytes |
| cfg_wr | input | 1 | Write alignment, offset and dump command |
| cfg_align | input | 2 | End alignment code |
| cfg_offset | input | 5 | Leading offset in bytes |
| cfg_dump | input | 1 | Flush command (acts with cfg_wr) |
| cnt_wr | input | 1 | Load the DWORD countdown |
| cnt_wdata | input | 12 | Countdown load value |
| irq_clr | input | 1 | Acknowledge the interrupt |
| rd_en | input | 1 | Host DWORD read |
| rd_data | output | 32 | Formatted DWORD |
| rd_avail | output | 1 | A DWORD can be read |
| irq | output | 1 | Countdown reached zero |
| cfg_rdata | output | 32 | Configuration and count readback |

## Verification
The bench targets packets whose offset and length put the last data byte in each lane. It also targets offsets that alone fill a whole DWORD, and lengths that land exactly on a boundary or one DWORD short of it. A design with a wrong rounding formula would give one DWORD too many or too few, or leave stale bytes in the tail lanes. A configuration change in the middle of a packet, and a dump with filler still owed, catch a formatter that re-samples its settings too late or that keeps stale pointers. The countdown is driven through reload, saturation, acknowledge and nonzero-reload cases, which expose an interrupt that fires a read early, wraps below zero, or cannot be cleared.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int CNT_W = 12;

  typedef enum logic [1:0] {
    AL_DW1  = 2'b00,
    AL_DW4  = 2'b01,
    AL_DW8  = 2'b10,
    AL_RSVD = 2'b11
  } end_align_e;

  // DWORD multiple a packet is padded to; the reserved code acts as 1
  function automatic int unsigned align_dwords(input logic [1:0] code);
    case (end_align_e'(code))
      AL_DW4:  return 4;
      AL_DW8:  return 8;
      default: return 1;
    endcase
  endfunction

  // total DWORDs read out for one packet, filler included
  function automatic int unsigned pkt_dwords(input int unsigned off,
                                             input int unsigned len,
                                             input logic [1:0] code);
    int unsigned data_dw;
    int unsigned mult;
    data_dw = (off + len + 3) >> 2;
    mult    = align_dwords(code);
    return (data_dw + mult - 1) & ~(mult - 1);
  endfunction

  // stream byte position p carries packet data
  function automatic logic lane_live(input int unsigned p,
                                     input int unsigned off,
                                     input int unsigned len);
    return (p >= off) && (p < off + len);
  endfunction

endpackage

// File: rtl/rxf_byte_fifo.sv
module rxf_byte_fifo #(
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [7:0]                 push_byte,
  input  logic [2:0]                 pop_cnt,
  output logic [3:0][7:0]            peek,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       full
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          push_ok;

  assign full    = (level == LW'(DEPTH));
  assign push_ok = push && !full && !flush;

  for (genvar g = 0; g < 4; g++) begin : g_peek
    assign peek[g] = mem[rd_ptr + AW'(g)];
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      rd_ptr <= rd_ptr + AW'(pop_cnt);
      level  <= level + LW'(push_ok) - LW'(pop_cnt);
    end
  end
endmodule

// File: rtl/rxf_stat_fifo.sv
module rxf_stat_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [LW-1:0] level;
  logic          push_ok;
  logic          pop_ok;

  assign empty   = (level == '0);
  assign push_ok = push && (level != LW'(DEPTH)) && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      level <= level + LW'(push_ok) - LW'(pop_ok);
    end
  end
endmodule

// File: rtl/rxf_lane_fmt.sv
module rxf_lane_fmt #(
  parameter int POS_W = 13
) (
  input  logic [POS_W-1:0] pos,
  input  logic [4:0]       off,
  input  logic [POS_W-1:0] len,
  input  logic [3:0][7:0]  peek,
  output logic [31:0]      dword,
  output logic [2:0]       need,
  output logic             in_pad
);
  logic [3:0]      live;
  logic [1:0]      first_lane;
  logic [3:0][1:0] src;
  int unsigned     pos_u;
  int unsigned     off_u;
  int unsigned     len_u;

  assign pos_u = 32'(pos);
  assign off_u = 32'(off);
  assign len_u = 32'(len);

  // lane of the first data byte when the offset ends inside this DWORD
  always_comb begin
    first_lane = 2'd0;
    if (off_u > pos_u && (off_u - pos_u) < 4) first_lane = 2'(off_u - pos_u);
  end

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign live[g]          = rxf_pkg::lane_live(pos_u + g, off_u, len_u);
    assign src[g]           = 2'(g) - first_lane;
    assign dword[8*g +: 8]  = live[g] ? peek[src[g]] : 8'h00;
  end

  assign need   = 3'($countones(live));
  assign in_pad = pos_u >= off_u + len_u;
endmodule

// File: rtl/rxf_countdown.sv
module rxf_countdown #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             dec,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             irq,
  output logic             irq_set
);
  assign irq_set = dec && !ld && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      if (ld)                    cnt <= ld_val;
      else if (dec && cnt != '0) cnt <= cnt - 1'b1;

      if (irq_set)                irq <= 1'b1;
      else if (ld && ld_val != '0) irq <= 1'b0;
      else if (clr)               irq <= 1'b0;
    end
  end
endmodule

// File: rtl/rxf_readout.sv
module rxf_readout #(
  parameter int DEPTH  = 64,
  parameter int SDEPTH = 4,
  parameter int LEN_W  = 11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [7:0]                in_byte,
  output logic                      in_ready,
  input  logic                      st_valid,
  input  logic [LEN_W-1:0]          st_len,
  input  logic                      cfg_wr,
  input  logic [1:0]                cfg_align,
  input  logic [4:0]                cfg_offset,
  input  logic                      cfg_dump,
  input  logic                      cnt_wr,
  input  logic [rxf_pkg::CNT_W-1:0] cnt_wdata,
  input  logic                      irq_clr,
  input  logic                      rd_en,
  output logic [31:0]               rd_data,
  output logic                      rd_avail,
  output logic                      irq,
  output logic [31:0]               cfg_rdata
);
  import rxf_pkg::*;

  localparam int POS_W = LEN_W + 2;
  localparam int LW    = $clog2(DEPTH) + 1;

  // configuration state
  logic [1:0] al_cfg, al_lat, al_eff;
  logic [4:0] off_cfg, off_lat, off_eff;
  logic       dump_q;
  logic       started;

  // datapath wires brought out for checking
  logic                dump_cmd;
  logic                full;
  logic [LW-1:0]       level;
  logic [3:0][7:0]     peek;
  logic [LEN_W-1:0]    head_len;
  logic                st_empty;
  logic [POS_W-1:0]    pos_q;
  logic [POS_W-1:0]    dw_idx;
  logic [POS_W-1:0]    tot_dw;
  logic [31:0]         fmt_word;
  logic [2:0]          need;
  logic                in_pad;
  logic                rd_fire;
  logic                last_dw;
  logic [2:0]          pop_cnt;
  logic [CNT_W-1:0]    cnt;
  logic                irq_set;

  assign dump_cmd = cfg_wr && cfg_dump;
  assign off_eff  = started ? off_lat : off_cfg;
  assign al_eff   = started ? al_lat  : al_cfg;

  rxf_byte_fifo #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rst_n(rst_n), .flush(dump_cmd),
    .push(in_valid), .push_byte(in_byte),
    .pop_cnt(pop_cnt), .peek(peek), .level(level), .full(full)
  );

  rxf_stat_fifo #(.DEPTH(SDEPTH), .W(LEN_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .flush(dump_cmd),
    .push(st_valid), .din(st_len),
    .pop(rd_fire && last_dw), .head(head_len), .empty(st_empty)
  );

  rxf_lane_fmt #(.POS_W(POS_W)) u_fmt (
    .pos(pos_q), .off(off_eff), .len(POS_W'(head_len)),
    .peek(peek), .dword(fmt_word), .need(need), .in_pad(in_pad)
  );

  rxf_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ld(cnt_wr), .ld_val(cnt_wdata),
    .dec(rd_fire), .clr(irq_clr), .cnt(cnt), .irq(irq), .irq_set(irq_set)
  );

  assign dw_idx   = pos_q >> 2;
  assign tot_dw   = POS_W'(pkt_dwords(32'(off_eff), 32'(head_len), al_eff));
  assign last_dw  = (dw_idx + 1'b1) == tot_dw;
  assign rd_avail = !st_empty && (level >= LW'(need));
  assign rd_fire  = rd_en && rd_avail && !dump_cmd;
  assign pop_cnt  = rd_fire ? need : 3'd0;
  assign rd_data  = rd_avail ? fmt_word : 32'h0;
  assign in_ready = !full;

  assign cfg_rdata = {4'b0, cnt, 3'b0, dump_q, 3'b0, off_cfg, 2'b0, al_cfg};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      al_cfg  <= '0;
      off_cfg <= '0;
      al_lat  <= '0;
      off_lat <= '0;
      dump_q  <= 1'b0;
      started <= 1'b0;
      pos_q   <= '0;
    end else begin
      dump_q <= dump_cmd;
      if (cfg_wr) begin
        al_cfg  <= cfg_align;
        off_cfg <= cfg_offset;
      end
      if (dump_cmd) begin
        pos_q   <= '0;
        started <= 1'b0;
      end else if (rd_fire) begin
        if (last_dw) begin
          pos_q   <= '0;
          started <= 1'b0;
        end else begin
          pos_q   <= pos_q + POS_W'(4);
          started <= 1'b1;
          if (!started) begin
            off_lat <= off_cfg;
            al_lat  <= al_cfg;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rxf_readout_chk.sv
module rxf_readout_chk #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 12,
  parameter int LW    = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_avail,
  input logic [31:0]      rd_data,
  input logic             in_pad,
  input logic             rd_fire,
  input logic             irq,
  input logic             irq_set,
  input logic             irq_clr,
  input logic [CNT_W-1:0] cnt,
  input logic             cnt_wr,
  input logic             dump_cmd,
  input logic             dump_q,
  input logic [LW-1:0]    level
);
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_avail |-> rd_data == 32'h0);

  p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_avail && in_pad) |-> rd_data == 32'h0);

  p_irq_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(rd_fire && cnt == CNT_W'(1)));

  p_cnt_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !cnt_wr) |=> cnt == '0);

  p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !irq_set) |=> !irq);

  p_dump_sc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_q && !dump_cmd) |=> !dump_q);

  p_dump_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dump_cmd |=> !rd_avail);

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
endmodule

bind rxf_readout rxf_readout_chk #(
  .DEPTH(DEPTH), .CNT_W(rxf_pkg::CNT_W), .LW(LW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_avail(rd_avail), .rd_data(rd_data),
  .in_pad(in_pad), .rd_fire(rd_fire), .irq(irq), .irq_set(irq_set),
  .irq_clr(irq_clr), .cnt(cnt), .cnt_wr(cnt_wr), .dump_cmd(dump_cmd),
  .dump_q(dump_q), .level(level)
);

// File: tb/tb_rxf_readout.sv
module tb_rxf_readout;
  localparam int DEPTH = 64;
  localparam int LEN_W = 11;
  // vector: offset, align code, length, pattern seed
  localparam int NV = 7;
  localparam int VEC [NV][4] = '{
    '{0, 0, 8, 1}, '{3, 0, 5, 2}, '{1, 1, 6, 3}, '{5, 2, 20, 4},
    '{30, 2, 33, 5}, '{2, 3, 9, 6}, '{31, 1, 1, 7}
  };

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, st_valid = 0, cfg_wr = 0, cfg_dump = 0;
  logic cnt_wr = 0, irq_clr = 0, rd_en = 0;
  logic [7:0] in_byte = 0;
  logic [LEN_W-1:0] st_len = 0;
  logic [1:0] cfg_align = 0;
  logic [4:0] cfg_offset = 0;
  logic [11:0] cnt_wdata = 0;
  logic in_ready, rd_avail, irq;
  logic [31:0] rd_data, cfg_rdata;

  int total = 0, bad = 0;
  logic [7:0] pkt [64];
  bit done = 0;

  always #10 clk = ~clk;

  rxf_readout #(.DEPTH(DEPTH), .SDEPTH(4), .LEN_W(LEN_W)) dut (.*);

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !done) begin
        bad++;
        $display("FAIL watchdog act=%0d exp=0", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 53 + i * 7 + 11) % 256);
  endfunction

  function automatic logic [31:0] exp_word(input int off, input int len, input int j);
    logic [31:0] w = 0;
    for (int k = 0; k < 4; k++) begin
      int p = 4 * j + k;
      if (p >= off && p < off + len) w[8*k +: 8] = pkt[p - off];
    end
    return w;
  endfunction

  function automatic int exp_total(input int off, input int len, input int al);
    int d = (off + len + 3) / 4;
    int m = (al == 1) ? 4 : (al == 2) ? 8 : 1;
    while (d % m != 0) d++;
    return d;
  endfunction

  task automatic push_bytes(input int n, input int seed, input int start);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1;
      in_byte = pat(seed, start + i);
      pkt[start + i] = in_byte;
    end
    @(negedge clk) in_valid = 0;
  endtask

  task automatic push_stat(input int len);
    @(negedge clk); st_valid = 1; st_len = LEN_W'(len);
    @(negedge clk) st_valid = 0;
  endtask

  task automatic set_cfg(input int al, input int off, input bit dmp);
    @(negedge clk); cfg_wr = 1; cfg_align = 2'(al); cfg_offset = 5'(off); cfg_dump = dmp;
    @(negedge clk) begin cfg_wr = 0; cfg_dump = 0; end
  endtask

  task automatic set_cnt(input int v);
    @(negedge clk); cnt_wr = 1; cnt_wdata = 12'(v);
    @(negedge clk) cnt_wr = 0;
  endtask

  task automatic rd(output logic [31:0] d, output logic a);
    @(negedge clk); d = rd_data; a = rd_avail; rd_en = 1;
    @(negedge clk) rd_en = 0;
  endtask

  task automatic read_seq(input int off, input int al, input int len,
                          input int from, input int upto, input string tag);
    logic [31:0] d; logic a;
    for (int j = from; j < upto; j++) begin
      rd(d, a);
      chk(a == 1'b1, tag, 32'(a), 32'd1);
      chk(d == exp_word(off, len, j), tag, d, exp_word(off, len, j));
    end
  endtask

  initial begin
    logic [31:0] d; logic a;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(rd_avail == 0 && rd_data == 0, "R10 read side", rd_data, 0);
    chk(irq == 0, "R10 irq", 32'(irq), 0);
    chk(cfg_rdata == 0, "R10 cfg_rdata", cfg_rdata, 0);
    chk(in_ready == 1, "R10 in_ready", 32'(in_ready), 1);
    rst_n = 1;

    // vector table: R1 R2 R4
    for (int v = 0; v < NV; v++) begin
      int off = VEC[v][0], al = VEC[v][1], len = VEC[v][2];
      set_cfg(al, off, 0);
      chk(cfg_rdata == {23'b0, 5'(off), 2'b0, 2'(al)}, "R12 layout", cfg_rdata,
          {23'b0, 5'(off), 2'b0, 2'(al)});
      push_bytes(len, VEC[v][3], 0);
      push_stat(len);
      read_seq(off, al, len, 0, exp_total(off, len, al), "R1/R2/R4 vector");
      @(negedge clk);
      chk(rd_avail == 0, "R1 packet end", 32'(rd_avail), 0);
    end

    // R3: settings changed after the first read leave the packet alone
    set_cfg(0, 0, 0);
    push_bytes(12, 9, 0);
    push_stat(12);
    read_seq(0, 0, 12, 0, 1, "R3 first");
    set_cfg(2, 8, 0);
    read_seq(0, 0, 12, 1, 3, "R3 rest");
    @(negedge clk);
    chk(rd_avail == 0, "R3 end", 32'(rd_avail), 0);
    push_bytes(4, 10, 0);
    push_stat(4);
    read_seq(8, 2, 4, 0, 8, "R3 next packet");

    // R8: dump mid-packet
    set_cfg(0, 0, 0);
    push_bytes(20, 11, 0);
    push_stat(20);
    read_seq(0, 0, 20, 0, 1, "R8 before");
    set_cfg(0, 0, 1);
    chk(cfg_rdata[12] == 1, "R8 flag pulse", 32'(cfg_rdata[12]), 1);
    chk(rd_avail == 0, "R8 emptied", 32'(rd_avail), 0);
    @(negedge clk);
    chk(cfg_rdata[12] == 0, "R8 self clear", 32'(cfg_rdata[12]), 0);
    push_bytes(4, 12, 0);
    push_stat(4);
    read_seq(0, 0, 4, 0, 1, "R8 fresh packet");
    @(negedge clk);
    chk(rd_avail == 0, "R8 no leftover", 32'(rd_avail), 0);

    // R9: incomplete DWORD
    set_cnt(5);
    push_stat(8);
    push_bytes(3, 13, 0);
    rd(d, a);
    chk(a == 0 && d == 0, "R9 empty read", d, 0);
    chk(cfg_rdata[27:16] == 5, "R9 count kept", 32'(cfg_rdata[27:16]), 5);
    push_bytes(5, 13, 3);
    read_seq(0, 0, 8, 0, 2, "R9 no advance");
    chk(cfg_rdata[27:16] == 3, "R5 decrement", 32'(cfg_rdata[27:16]), 3);
    set_cnt(0);

    // R5 R6 R7: countdown
    set_cnt(3);
    push_bytes(16, 14, 0);
    push_stat(16);
    read_seq(0, 0, 16, 0, 2, "R5 data");
    chk(cfg_rdata[27:16] == 1 && irq == 0, "R5 count one", 32'(cfg_rdata[27:16]), 1);
    set_cnt(2);
    chk(cfg_rdata[27:16] == 2, "R6 reload", 32'(cfg_rdata[27:16]), 2);
    read_seq(0, 0, 16, 2, 3, "R6 data");
    chk(irq == 0, "R6 no early irq", 32'(irq), 0);
    read_seq(0, 0, 16, 3, 4, "R5 data");
    chk(irq == 1 && cfg_rdata[27:16] == 0, "R5 irq at zero", 32'(irq), 1);
    push_bytes(4, 15, 0);
    push_stat(4);
    read_seq(0, 0, 4, 0, 1, "R5 data");
    chk(cfg_rdata[27:16] == 0, "R5 floor", 32'(cfg_rdata[27:16]), 0);
    chk(irq == 1, "R5 irq held", 32'(irq), 1);
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    chk(irq == 0, "R7 ack", 32'(irq), 0);
    set_cnt(1);
    push_bytes(4, 16, 0);
    push_stat(4);
    read_seq(0, 0, 4, 0, 1, "R6 data");
    chk(irq == 1, "R5 irq again", 32'(irq), 1);
    set_cnt(5);
    chk(irq == 0, "R6 nonzero load clears", 32'(irq), 0);
    set_cnt(0);

    // R11: full byte FIFO
    push_bytes(DEPTH, 17, 0);
    chk(in_ready == 0, "R11 full", 32'(in_ready), 0);
    set_cfg(0, 0, 1);
    chk(in_ready == 1, "R11 after dump", 32'(in_ready), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule